// File: doc/BRIEF.md
# Rotating frame-buffer address translator

This block sits between a bus master and external memory and turns a virtual address into a physical one. An image is stored once in a page-tiled layout. A master can then read or write it as if it were rotated by 0, 90, 180 or 270 degrees, by choosing one of four 16 MB virtual windows. Inside a window the address is read as a linear picture with a fixed pitch of 2048 pixels per line. The block splits the address into a view column and a view row. It maps them back to the stored image's coordinates, then finds the page and the byte inside that page.

Software sets the page shape, pixel size, image size and page-aligned base address through a small write-only register port. Translations are issued one per cycle at most, with no stall. Each request produces exactly one response after a fixed latency of one or two cycles, chosen by parameter. A request that falls outside the image, or outside the windows, is flagged and gets a zero address, so no memory access is made for it.

Top module: `rotview_xlate`

## Requirements
- R1: After reset, rsp_valid is low and the configuration holds page width code 5, page height code 5, pixel code 1, image width 0, image height 0 and base 0. With these values every in-window request is out of range.
- R2: A write with cfg_addr 0 sets the page width code from cfg_wdata[2:0], the page height code from [6:4] and the pixel code from [9:8]. Address 1 sets image width from [10:0] and image height from [26:16]. Address 2 sets the 31-bit base. Later translations use the new values.
- R3: A request is inside a window only when req_vaddr[31:26] equals 6'h1D. Bits [25:24] then select the angle: 0, 1, 2 and 3 select 0, 90, 180 and 270 degrees. Any other address is reported out of range.
- R4: With pixel code p (2^p bytes per pixel) and window offset o = req_vaddr[23:0]: the view column is (o >> p) mod 2048, the view row is o >> (p+11), and the low p bits of o select the byte inside the pixel. That byte selection is carried into the physical address unchanged.
- R5: A view pixel (c, r) maps to the stored pixel (x, y) as follows, with image width W and height H:
  - 0 degrees gives (c, r).
  - 90 degrees gives (r, H-1-c).
  - 180 degrees gives (W-1-c, H-1-r).
  - 270 degrees gives (W-1-r, c).
- R6: The view width is H at 90 and 270 degrees and W otherwise; the view height is the other dimension. A request whose column is not below the view width, or whose row is not below the view height, returns rsp_oor high and rsp_paddr zero.
- R7: Take pages of 2^pw bytes by 2^ph lines, and b = x*2^p + byte-in-pixel. The physical address is base + ((y >> ph) * pages_per_line + (b >> pw)) * 2^(pw+ph) + (y mod 2^ph) * 2^pw + (b mod 2^pw).
- R8: pages_per_line is W * 2^p bytes divided by the page width in bytes, rounded up to a whole page.
- R9: Each accepted request yields exactly one response, in order, exactly LATENCY cycles later (default 2). Requests may be issued back to back.
- R10: A write with cfg_addr 3 changes no configuration value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 31 | Configuration write data |
| req_valid | input | 1 | Translate request present |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result present |
| rsp_paddr | output | 32 | Physical address, zero when out of range |
| rsp_oor | output | 1 | Request fell outside the image or the windows |

## Verification
A wrong angle decode, a swapped dimension or an off-by-one in the mirror terms shows up as a wrong rsp_paddr or a wrong rsp_oor. It appears on the very response that carries the affected pixel, LATENCY cycles after the request, so the sweep probes corners and edge pixels of each angle. A wrong page count per line or a wrong page-shape decode moves every pixel beyond the first page row or column. Non-square pages and both pixel sizes expose it within a few requests. A lost or duplicated pipeline slot appears as a response in the wrong cycle, a missing response, or a surplus one.

// File: rtl/rotview_pkg.sv
`timescale 1ns/1ps
package rotview_pkg;

   localparam int unsigned RV_COORD_W  = 11;
   localparam int unsigned RV_PGCODE_W = 3;
   localparam int unsigned RV_PXCODE_W = 2;
   localparam int unsigned RV_BASE_W   = 31;
   localparam int unsigned RV_BLO_W    = (1 << RV_PXCODE_W) - 1;

   typedef enum logic [1:0] {
      ROT_0   = 2'd0,
      ROT_90  = 2'd1,
      ROT_180 = 2'd2,
      ROT_270 = 2'd3
   } rot_angle_e;

   typedef struct packed {
      logic [RV_PGCODE_W-1:0] pw_log2;
      logic [RV_PGCODE_W-1:0] ph_log2;
      logic [RV_PXCODE_W-1:0] px_log2;
      logic [RV_COORD_W-1:0]  img_w;
      logic [RV_COORD_W-1:0]  img_h;
      logic [RV_BASE_W-1:0]   base;
   } rot_cfg_t;

   typedef struct packed {
      logic                  oor;
      logic [RV_COORD_W-1:0] x;
      logic [RV_COORD_W-1:0] y;
      logic [RV_BLO_W-1:0]   byte_lo;
   } rot_pix_t;

endpackage

// File: rtl/rotview_regs.sv
`timescale 1ns/1ps
module rotview_regs
   import rotview_pkg::*;
#(
   parameter int unsigned RST_PW = 5,
   parameter int unsigned RST_PH = 5,
   parameter int unsigned RST_PX = 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [RV_BASE_W-1:0] wr_data,
   output rot_cfg_t             cfg
);

   localparam logic [1:0]  SEL_GEOM = 2'd0;
   localparam logic [1:0]  SEL_SIZE = 2'd1;
   localparam logic [1:0]  SEL_BASE = 2'd2;
   localparam int unsigned PH_LSB   = 4;
   localparam int unsigned PX_LSB   = 8;
   localparam int unsigned HGT_LSB  = 16;

   if (RST_PW >= (1 << RV_PGCODE_W) || RST_PH >= (1 << RV_PGCODE_W)) begin : g_bad_pg
      $error("rotview_regs: page code reset value does not fit");
   end
   if (RST_PX >= (1 << RV_PXCODE_W)) begin : g_bad_px
      $error("rotview_regs: pixel code reset value does not fit");
   end
   if (HGT_LSB + RV_COORD_W > RV_BASE_W) begin : g_bad_size
      $error("rotview_regs: size fields exceed write data width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.pw_log2 <= RV_PGCODE_W'(RST_PW);
         cfg.ph_log2 <= RV_PGCODE_W'(RST_PH);
         cfg.px_log2 <= RV_PXCODE_W'(RST_PX);
         cfg.img_w   <= '0;
         cfg.img_h   <= '0;
         cfg.base    <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_GEOM: begin
               cfg.pw_log2 <= wr_data[RV_PGCODE_W-1:0];
               cfg.ph_log2 <= wr_data[PH_LSB +: RV_PGCODE_W];
               cfg.px_log2 <= wr_data[PX_LSB +: RV_PXCODE_W];
            end
            SEL_SIZE: begin
               cfg.img_w <= wr_data[RV_COORD_W-1:0];
               cfg.img_h <= wr_data[HGT_LSB +: RV_COORD_W];
            end
            SEL_BASE: cfg.base <= wr_data;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/rotview_decode.sv
`timescale 1ns/1ps
module rotview_decode
   import rotview_pkg::*;
#(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned WIN_LOG2 = 24,
   parameter int unsigned WIN_TAG  = 'h1D
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vld,
   input  logic [VA_W-1:0]        vaddr,
   input  logic [RV_PXCODE_W-1:0] px_log2,
   input  logic [RV_COORD_W-1:0]  img_w,
   input  logic [RV_COORD_W-1:0]  img_h,
   output rot_pix_t               pix
);

   localparam int unsigned TAG_W = VA_W - WIN_LOG2 - 2;
   localparam int unsigned OFF_W = WIN_LOG2;
   localparam int unsigned ROW_W = OFF_W - RV_COORD_W;

   logic                  in_win;
   rot_angle_e            ang;
   logic [OFF_W-1:0]      off;
   logic [OFF_W-1:0]      pix_idx;
   logic [RV_COORD_W-1:0] col;
   logic [ROW_W-1:0]      row;
   logic [RV_COORD_W-1:0] row_lo;
   logic [RV_COORD_W-1:0] view_w;
   logic [RV_COORD_W-1:0] view_h;
   logic [RV_BLO_W-1:0]   lo_mask;
   logic [RV_COORD_W-1:0] one;

   assign one     = RV_COORD_W'(1);
   assign in_win  = (vaddr[VA_W-1 -: TAG_W] == TAG_W'(WIN_TAG));
   assign ang     = rot_angle_e'(vaddr[WIN_LOG2 +: 2]);
   assign off     = vaddr[OFF_W-1:0];
   assign pix_idx = off >> px_log2;
   assign col     = pix_idx[RV_COORD_W-1:0];
   assign row     = pix_idx[OFF_W-1:RV_COORD_W];
   assign row_lo  = row[RV_COORD_W-1:0];
   assign lo_mask = ~({RV_BLO_W{1'b1}} << px_log2);

   // Quarter turns swap the view dimensions
   assign view_w = ang[0] ? img_h : img_w;
   assign view_h = ang[0] ? img_w : img_h;

   always_comb begin
      pix.oor     = !in_win || (col >= view_w) || (row >= ROW_W'(view_h));
      pix.byte_lo = off[RV_BLO_W-1:0] & lo_mask;
      pix.x       = col;
      pix.y       = row_lo;
      case (ang)
         ROT_0: begin
            pix.x = col;
            pix.y = row_lo;
         end
         ROT_90: begin
            pix.x = row_lo;
            pix.y = img_h - one - col;
         end
         ROT_180: begin
            pix.x = img_w - one - col;
            pix.y = img_h - one - row_lo;
         end
         ROT_270: begin
            pix.x = img_w - one - row_lo;
            pix.y = col;
         end
      endcase
   end

   // R3
   win_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld && (vaddr[VA_W-1 -: TAG_W] != TAG_W'(WIN_TAG)) |-> pix.oor);

   // R5
   coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld && !pix.oor |-> (pix.x < img_w) && (pix.y < img_h));

endmodule

// File: rtl/rotview_place.sv
`timescale 1ns/1ps
module rotview_place
   import rotview_pkg::*;
#(
   parameter int unsigned PA_W = 32
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vld,
   input  rot_pix_t               pix,
   input  logic [RV_PGCODE_W-1:0] pw_log2,
   input  logic [RV_PGCODE_W-1:0] ph_log2,
   input  logic [RV_PXCODE_W-1:0] px_log2,
   input  logic [RV_COORD_W-1:0]  img_w,
   input  logic [RV_BASE_W-1:0]   base,
   output logic [PA_W-1:0]        paddr
);

   localparam int unsigned BX_W = RV_COORD_W + RV_BLO_W;

   logic [BX_W-1:0]        bx;
   logic [BX_W-1:0]        pw_mask;
   logic [BX_W-1:0]        page_col;
   logic [BX_W-1:0]        byte_in_row;
   logic [BX_W-1:0]        line_bytes;
   logic [BX_W:0]          per_line;
   logic [RV_COORD_W-1:0]  ph_mask;
   logic [RV_COORD_W-1:0]  row_in_page;
   logic [RV_COORD_W-1:0]  page_row;
   logic [RV_PGCODE_W:0]   tile_sh;
   logic [PA_W-1:0]        page_idx;
   logic [PA_W-1:0]        tile_off;
   logic [PA_W-1:0]        line_off;

   // Byte position of the pixel along the stored line
   assign bx          = (BX_W'(pix.x) << px_log2) | BX_W'(pix.byte_lo);
   assign pw_mask     = ~({BX_W{1'b1}} << pw_log2);
   assign page_col    = bx >> pw_log2;
   assign byte_in_row = bx & pw_mask;

   // Whole pages needed to hold one stored line
   assign line_bytes  = BX_W'(img_w) << px_log2;
   assign per_line    = ({1'b0, line_bytes} + {1'b0, pw_mask}) >> pw_log2;

   assign ph_mask     = ~({RV_COORD_W{1'b1}} << ph_log2);
   assign row_in_page = pix.y & ph_mask;
   assign page_row    = pix.y >> ph_log2;

   assign tile_sh  = {1'b0, pw_log2} + {1'b0, ph_log2};
   assign page_idx = PA_W'(page_row) * PA_W'(per_line) + PA_W'(page_col);
   assign tile_off = page_idx << tile_sh;
   assign line_off = PA_W'(row_in_page) << pw_log2;
   assign paddr    = PA_W'(base) + tile_off + line_off + PA_W'(byte_in_row);

   // R7
   phys_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld && !pix.oor |-> paddr >= PA_W'(base));

endmodule

// File: rtl/rotview_xlate.sv
`timescale 1ns/1ps
module rotview_xlate
   import rotview_pkg::*;
#(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned PA_W     = 32,
   parameter int unsigned WIN_LOG2 = 24,
   parameter int unsigned WIN_TAG  = 'h1D,
   parameter int unsigned LATENCY  = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_addr,
   input  logic [RV_BASE_W-1:0] cfg_wdata,
   input  logic                 req_valid,
   input  logic [VA_W-1:0]      req_vaddr,
   output logic                 rsp_valid,
   output logic [PA_W-1:0]      rsp_paddr,
   output logic                 rsp_oor
);

   localparam int unsigned TAG_W = VA_W - WIN_LOG2 - 2;

   if (LATENCY < 1 || LATENCY > 2) begin : g_bad_lat
      $error("rotview_xlate: LATENCY must be 1 or 2");
   end
   if (VA_W < WIN_LOG2 + 3) begin : g_bad_va
      $error("rotview_xlate: no room for window tag and angle");
   end
   if (WIN_LOG2 <= RV_COORD_W + RV_BLO_W) begin : g_bad_win
      $error("rotview_xlate: window too small for one line");
   end
   if (PA_W < RV_BASE_W) begin : g_bad_pa
      $error("rotview_xlate: physical address narrower than base");
   end
   if (WIN_TAG >= (1 << TAG_W)) begin : g_bad_tag
      $error("rotview_xlate: window tag does not fit");
   end

   rot_cfg_t        cfg;
   rot_pix_t        pix_a;
   rot_pix_t        pix_b;
   logic            vld_b;
   logic [PA_W-1:0] paddr_b;

   rotview_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_addr),
      .wr_data (cfg_wdata),
      .cfg     (cfg)
   );

   rotview_decode #(
      .VA_W     (VA_W),
      .WIN_LOG2 (WIN_LOG2),
      .WIN_TAG  (WIN_TAG)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (req_valid),
      .vaddr   (req_vaddr),
      .px_log2 (cfg.px_log2),
      .img_w   (cfg.img_w),
      .img_h   (cfg.img_h),
      .pix     (pix_a)
   );

   if (LATENCY == 2) begin : g_mid_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_b <= 1'b0;
            pix_b <= '0;
         end else begin
            vld_b <= req_valid;
            pix_b <= pix_a;
         end
      end
   end else begin : g_mid_wire
      assign vld_b = req_valid;
      assign pix_b = pix_a;
   end

   rotview_place #(
      .PA_W (PA_W)
   ) u_place (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (vld_b),
      .pix     (pix_b),
      .pw_log2 (cfg.pw_log2),
      .ph_log2 (cfg.ph_log2),
      .px_log2 (cfg.px_log2),
      .img_w   (cfg.img_w),
      .base    (cfg.base),
      .paddr   (paddr_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_oor   <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= vld_b;
         rsp_oor   <= pix_b.oor;
         rsp_paddr <= pix_b.oor ? '0 : paddr_b;
      end
   end

   // R9
   rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid, LATENCY));

   // R6
   oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_oor |-> rsp_paddr == '0);

endmodule

// File: tb/rotview_xlate_test.sv
`timescale 1ns/1ps
module rotview_xlate_test;

   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [30:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_oor;

   always #2.5 clk = ~clk;

   rotview_xlate #(.LATENCY(LAT)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .req_valid (req_valid),
      .req_vaddr (req_vaddr),
      .rsp_valid (rsp_valid),
      .rsp_paddr (rsp_paddr),
      .rsp_oor   (rsp_oor)
   );

   // Bench copy of the configuration, reset values per R1
   int     m_pw = 5, m_ph = 5, m_px = 1, m_w = 0, m_h = 0;
   longint m_base = 0;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   logic [32:0] exp_q[$];
   int          due_q[$];
   string       tag_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic logic [32:0] model(input logic [31:0] va);
      longint pb, off, col, row, bl, vw, vh, x, y, bx, pwb, phr, ppl, a;
      int ang;
      pb  = longint'(1) << m_px;
      off = longint'(va[23:0]);
      ang = int'(va[25:24]);
      col = (off / pb) % 2048;
      row = off / (pb * 2048);
      bl  = off % pb;
      vw  = (ang % 2 == 1) ? m_h : m_w;
      vh  = (ang % 2 == 1) ? m_w : m_h;
      if (va[31:26] != 6'h1D || col >= vw || row >= vh) return {1'b1, 32'h0};
      case (ang)
         0:       begin x = col;           y = row;           end
         1:       begin x = row;           y = m_h - 1 - col; end
         2:       begin x = m_w - 1 - col; y = m_h - 1 - row; end
         default: begin x = m_w - 1 - row; y = col;           end
      endcase
      bx  = x * pb + bl;
      pwb = longint'(1) << m_pw;
      phr = longint'(1) << m_ph;
      ppl = (m_w * pb + pwb - 1) / pwb;
      a   = m_base + ((y / phr) * ppl + bx / pwb) * pwb * phr + (y % phr) * pwb + bx % pwb;
      return {1'b0, a[31:0]};
   endfunction

   function automatic logic [31:0] mk(input int ang, input int col, input int row, input int bl);
      longint o;
      o = longint'(row) * (longint'(2048) << m_px) + longint'(col) * (longint'(1) << m_px) + bl;
      return {6'h1D, 2'(ang), o[23:0]};
   endfunction

   task automatic send_exp(input logic [31:0] va, input logic e_oor, input logic [31:0] e_pa,
                           input string tag);
      @(negedge clk);
      exp_q.push_back({e_oor, e_pa});
      due_q.push_back(cyc + LAT);
      tag_q.push_back(tag);
      req_valid = 1'b1;
      req_vaddr = va;
   endtask

   task automatic send(input logic [31:0] va, input string tag);
      logic [32:0] e;
      e = model(va);
      send_exp(va, e[32], e[31:0], tag);
   endtask

   task automatic drain();
      @(negedge clk);
      req_valid = 1'b0;
      repeat (LAT + 2) @(negedge clk);
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [30:0] d);
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      case (a)
         2'd0: begin m_pw = int'(d[2:0]); m_ph = int'(d[6:4]); m_px = int'(d[9:8]); end
         2'd1: begin m_w = int'(d[10:0]); m_h = int'(d[26:16]); end
         2'd2: m_base = longint'(d);
         default: ;
      endcase
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_geom(input int pw, input int ph, input int px, input int w, input int h,
                           input logic [30:0] base);
      cfg_write(2'd0, 31'((px << 8) | (ph << 4) | pw));
      cfg_write(2'd1, 31'((h << 16) | w));
      cfg_write(2'd2, base);
   endtask

   // Corners, an interior pixel and the first pixels past each edge, all angles
   task automatic sweep(input string tag);
      for (int ang = 0; ang < 4; ang++) begin
         int vw, vh;
         vw = (ang % 2 == 1) ? m_h : m_w;
         vh = (ang % 2 == 1) ? m_w : m_h;
         send(mk(ang, 0, 0, 0), tag);
         send(mk(ang, vw - 1, 0, 0), tag);
         send(mk(ang, 0, vh - 1, 0), tag);
         send(mk(ang, vw - 1, vh - 1, 0), tag);
         send(mk(ang, vw / 2, vh / 3, (1 << m_px) - 1), tag);
         send(mk(ang, vw, 0, 0), "R6");
         send(mk(ang, 0, vh, 0), "R6");
      end
      drain();
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      logic [32:0] e;
      int          d;
      string       t;
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected response count", 64'(1), 64'(0));
         end else begin
            e = exp_q.pop_front();
            d = due_q.pop_front();
            t = tag_q.pop_front();
            check(rsp_oor == e[32], t, "rsp_oor", 64'(rsp_oor), 64'(e[32]));
            check(rsp_paddr == e[31:0], t, "rsp_paddr", 64'(rsp_paddr), 64'(e[31:0]));
            check(cyc == d, "R9", "response cycle", 64'(cyc), 64'(d));
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      check(1'b0, "R9", "watchdog cycle", 64'(cyc), 64'(0));
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: no response while held in reset
      check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'(0));

      // R1: zero image size after reset, so an in-window request is out of range
      send_exp(32'h7400_0000, 1'b1, 32'h0, "R1");
      drain();

      // R1: default page and pixel codes with a 64x64 image, col 20 row 3 -> 0x468
      cfg_write(2'd1, 31'((64 << 16) | 64));
      send_exp(mk(0, 20, 3, 0), 1'b0, 32'h0000_0468, "R1");
      drain();

      // R2: 32x32-byte pages, 32-bit pixels, 160x256 image
      set_geom(5, 5, 2, 160, 256, 31'h0030_0000);
      // R7: angle 0, col 10 row 40 -> 0x305508
      send_exp(mk(0, 10, 40, 0), 1'b0, 32'h0030_5508, "R7");
      // R5: angle 90, col 5 row 7 -> stored (7,250) -> 0x32335C
      send_exp(mk(1, 5, 7, 0), 1'b0, 32'h0032_335C, "R5");
      // R4: byte 3 of pixel (3,2) -> 0x30004F
      send_exp(mk(0, 3, 2, 3), 1'b0, 32'h0030_004F, "R4");
      drain();
      sweep("R2");

      // R3: addresses outside the four windows
      send_exp(32'h7800_0010, 1'b1, 32'h0, "R3");
      send_exp(32'h7000_0000, 1'b1, 32'h0, "R3");
      send_exp(32'hF400_0000, 1'b1, 32'h0, "R3");
      send(mk(3, 1, 1, 0), "R3");
      drain();

      // R10: select 3 leaves every setting as it was
      cfg_write(2'd3, 31'h7FFF_FFFF);
      send_exp(mk(0, 10, 40, 0), 1'b0, 32'h0030_5508, "R10");
      send(mk(2, 159, 255, 0), "R10");
      drain();

      // R8: 32x64 pages, 16-bit pixels, width 100 -> 7 pages per line
      set_geom(5, 6, 1, 100, 240, 31'h1234_0000);
      send_exp(mk(0, 99, 0, 0), 1'b0, 32'h1234_3006, "R8");
      send_exp(mk(0, 0, 1, 0), 1'b0, 32'h1234_0020, "R8");
      send(mk(0, 50, 64, 1), "R8");
      drain();
      sweep("R5");

      // R4: byte pixels with the widest image and 64-byte by 16-line pages
      set_geom(6, 4, 0, 2047, 3, 31'h0000_0000);
      send(mk(0, 2046, 2, 0), "R4");
      sweep("R4");

      // R7: 320x240 16-bit image on 32x64-byte pages
      set_geom(5, 6, 1, 320, 240, 31'h0010_0800);
      sweep("R7");

      drain();
      // R9: every request received its response
      check(exp_q.size() == 0, "R9", "pending responses", 64'(exp_q.size()), 64'(0));
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule